// File: doc/BRIEF.md
# Tone Duration Steering Validator

This block decides when a dual-tone digit is real. A frequency detector upstream raises a presence flag while it sees a valid tone pair and offers a 4-bit decoded code. The validator times the flag with counters instead of an analogue RC network. A digit is registered only when the flag has stayed high for a run-time acquisition count. Registering loads the code into an output latch and raises a guard output. After a settle count, the delayed steering flag rises to tell downstream logic that a new digit is ready.

The same timing runs the other way to check the pause between digits. While a digit is held, the flag must stay low for a release count before the steering flag falls. A short dropout therefore leaves the digit registered. The latched code reaches the output bus only while the output enable is high. Otherwise the bus is marked as not driven and reads as zero.

All three counts are inputs given in clock cycles. A count of zero acts as one.

Top module: `tone_steer_validator`

## Requirements
- R1: With acquisition count A (0 treated as 1), the latch loads at the clock edge that samples `presenceIn` high for the A-th consecutive time. It never loads at an edge that samples `presenceIn` low.
- R2: At that edge the latch takes `codeIn`. It then keeps that value until the next registration, including after release and while `codeIn` changes.
- R3: `guardOut` rises at the same edge as the latch load. It stays high while `presenceIn` is sampled high and falls at the first edge that samples `presenceIn` low. It does not rise again without a new registration.
- R4: With settle count S (0 treated as 1), `steerOut` rises exactly S clock edges after the latch load. It is low at the load edge.
- R5: While `outEnable` is 1, `codeOut` shows the latched code and `busDrive` is 1. While `outEnable` is 0, `codeOut` is 4'h0 and `busDrive` is 0. This output path has no clock delay.
- R6: While a digit is held, with release count R (0 treated as 1), `steerOut` falls at the edge that samples `presenceIn` low for the R-th consecutive time. A low run shorter than R, followed by a high sample, leaves `steerOut` high and the latch unchanged.
- R7: A high burst shorter than A samples leaves `guardOut`, `steerOut` and the latch unchanged.
- R8: A low sample during acquisition restarts the count from zero. Two high runs that are each shorter than A, split by one low sample, do not register a digit.
- R9: After reset, `guardOut` and `steerOut` are 0 and the latch holds 4'h0. After a release, a new acquisition starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| presenceIn | input | 1 | Early presence flag from the tone detector |
| codeIn | input | 4 | Decoded digit code from the detector |
| acqCycles | input | 16 | Acquisition count in clock cycles |
| settleCycles | input | 16 | Settle count from latch load to steering flag |
| relCycles | input | 16 | Release count of low samples that ends a digit |
| outEnable | input | 1 | Output bus enable |
| codeOut | output | 4 | Latched code gated by `outEnable` |
| busDrive | output | 1 | High when the bus is driven |
| guardOut | output | 1 | Guard output |
| steerOut | output | 1 | Delayed steering flag |

## Verification
A table of bursts covers several acquisition, settle and release counts, including zero counts and single-cycle counts. For each burst the bench measures the edge at which guard and steering rise and fall, which exposes off-by-one errors in each of the three counters separately. One burst is exactly one sample short of acquisition, to separate rejection from registration at the boundary. Directed patterns then send a dropout one sample shorter than the release count, two split high runs that test whether the count restarts, a code change while a digit is held, and output-enable toggling. These patterns tell a true pause apart from a dropout, and a counter that restarts from one that merely pauses.

// File: rtl/tone_steer_pkg.sv
package tone_steer_pkg;

  typedef enum logic [1:0] {
    LIM_ACQ    = 2'd0,
    LIM_SETTLE = 2'd1,
    LIM_REL    = 2'd2
  } limSel_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_HELD   = 2'd2
  } steerState_e;

  typedef struct packed {
    logic    cntClr;
    logic    cntInc;
    logic    loadCode;
    limSel_e limSel;
  } steerStrobes_t;

endpackage

// File: rtl/tone_steer_ctrl.sv
module tone_steer_ctrl
  import tone_steer_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          presenceIn,
  input  logic          cntHit,
  output steerStrobes_t strobes,
  output logic          guardOut,
  output logic          steerOut
);

  steerState_e state;
  steerState_e nextState;

  always_comb begin
    strobes   = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        strobes.limSel = LIM_ACQ;
        if (presenceIn) begin
          if (cntHit) begin
            strobes.loadCode = 1'b1;
            strobes.cntClr   = 1'b1;
            nextState        = ST_SETTLE;
          end else begin
            strobes.cntInc = 1'b1;
          end
        end else begin
          // any gap restarts acquisition
          strobes.cntClr = 1'b1;
        end
      end
      ST_SETTLE: begin
        strobes.limSel = LIM_SETTLE;
        if (cntHit) begin
          strobes.cntClr = 1'b1;
          nextState      = ST_HELD;
        end else begin
          strobes.cntInc = 1'b1;
        end
      end
      ST_HELD: begin
        strobes.limSel = LIM_REL;
        if (!presenceIn) begin
          if (cntHit) begin
            strobes.cntClr = 1'b1;
            nextState      = ST_IDLE;
          end else begin
            strobes.cntInc = 1'b1;
          end
        end else begin
          // tone came back: dropout forgiven
          strobes.cntClr = 1'b1;
        end
      end
      default: begin
        strobes.cntClr = 1'b1;
        nextState      = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      guardOut <= 1'b0;
      steerOut <= 1'b0;
    end else begin
      state    <= nextState;
      guardOut <= strobes.loadCode | (guardOut & presenceIn);
      steerOut <= (nextState == ST_HELD);
    end
  end

endmodule

// File: rtl/tone_steer_dp.sv
module tone_steer_dp
  import tone_steer_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  steerStrobes_t     strobes,
  input  logic [CODE_W-1:0] codeIn,
  input  logic [CNT_W-1:0]  acqCycles,
  input  logic [CNT_W-1:0]  settleCycles,
  input  logic [CNT_W-1:0]  relCycles,
  input  logic              outEnable,
  output logic              cntHit,
  output logic [CODE_W-1:0] codeOut,
  output logic              busDrive
);

  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  limit;
  logic [EXT_W-1:0]  cntPlusOne;
  logic [CODE_W-1:0] codeLatch;

  always_comb begin
    case (strobes.limSel)
      LIM_ACQ:    limit = acqCycles;
      LIM_SETTLE: limit = settleCycles;
      LIM_REL:    limit = relCycles;
      default:    limit = acqCycles;
    endcase
  end

  // a limit of zero is met on the first counted cycle, same as one
  assign cntPlusOne = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
  assign cntHit     = cntPlusOne >= {1'b0, limit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobes.cntClr) begin
      cnt <= '0;
    end else if (strobes.cntInc) begin
      cnt <= cntPlusOne[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeLatch <= '0;
    end else if (strobes.loadCode) begin
      codeLatch <= codeIn;
    end
  end

  assign busDrive = outEnable;
  assign codeOut  = outEnable ? codeLatch : '0;

endmodule

// File: rtl/tone_steer_validator.sv
module tone_steer_validator
  import tone_steer_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              presenceIn,
  input  logic [CODE_W-1:0] codeIn,
  input  logic [CNT_W-1:0]  acqCycles,
  input  logic [CNT_W-1:0]  settleCycles,
  input  logic [CNT_W-1:0]  relCycles,
  input  logic              outEnable,
  output logic [CODE_W-1:0] codeOut,
  output logic              busDrive,
  output logic              guardOut,
  output logic              steerOut
);

  steerStrobes_t strobes;
  logic          cntHit;

  tone_steer_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .presenceIn (presenceIn),
    .cntHit     (cntHit),
    .strobes    (strobes),
    .guardOut   (guardOut),
    .steerOut   (steerOut)
  );

  tone_steer_dp #(
    .CODE_W (CODE_W),
    .CNT_W  (CNT_W)
  ) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .codeIn       (codeIn),
    .acqCycles    (acqCycles),
    .settleCycles (settleCycles),
    .relCycles    (relCycles),
    .outEnable    (outEnable),
    .cntHit       (cntHit),
    .codeOut      (codeOut),
    .busDrive     (busDrive)
  );

endmodule

// File: rtl/tone_steer_checker.sv
module tone_steer_checker #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              presenceIn,
  input logic              outEnable,
  input logic [CODE_W-1:0] codeOut,
  input logic              busDrive,
  input logic              guardOut,
  input logic              steerOut
);

  assert_guard_needs_tone_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(guardOut) |-> $past(presenceIn));

  assert_code_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (steerOut && $past(steerOut) && outEnable && $past(outEnable)) |-> $stable(codeOut));

  assert_guard_drops_R3: assert property (@(posedge clk) disable iff (!rstN)
    (guardOut && !presenceIn) |=> !guardOut);

  assert_steer_after_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(guardOut) |-> !steerOut);

  assert_bus_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    !busDrive |-> (codeOut == '0));

  assert_release_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(steerOut) |-> !$past(presenceIn));

endmodule

bind tone_steer_validator tone_steer_checker #(.CODE_W(CODE_W)) i_checker (
  .clk        (clk),
  .rstN       (rstN),
  .presenceIn (presenceIn),
  .outEnable  (outEnable),
  .codeOut    (codeOut),
  .busDrive   (busDrive),
  .guardOut   (guardOut),
  .steerOut   (steerOut)
);

// File: tb/test_tone_steer_validator.sv
module test_tone_steer_validator;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        presenceIn = 1'b0;
  logic [3:0]  codeIn = 4'h0;
  logic [15:0] acqCycles = 16'd1;
  logic [15:0] settleCycles = 16'd1;
  logic [15:0] relCycles = 16'd1;
  logic        outEnable = 1'b1;
  logic [3:0]  codeOut;
  logic        busDrive;
  logic        guardOut;
  logic        steerOut;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  tone_steer_validator i_tone_steer_validator (
    .clk          (clk),
    .rstN         (rstN),
    .presenceIn   (presenceIn),
    .codeIn       (codeIn),
    .acqCycles    (acqCycles),
    .settleCycles (settleCycles),
    .relCycles    (relCycles),
    .outEnable    (outEnable),
    .codeOut      (codeOut),
    .busDrive     (busDrive),
    .guardOut     (guardOut),
    .steerOut     (steerOut)
  );

  typedef struct packed {
    logic [15:0] acq;
    logic [15:0] settle;
    logic [15:0] rel;
    logic [3:0]  code;
    logic [15:0] hiLen;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{16'd5, 16'd2, 16'd4, 4'h3, 16'd12},
    '{16'd1, 16'd1, 16'd1, 4'hA, 16'd3},
    '{16'd8, 16'd3, 16'd6, 4'h5, 16'd7},
    '{16'd8, 16'd3, 16'd6, 4'h5, 16'd11},
    '{16'd0, 16'd0, 16'd2, 4'hF, 16'd2},
    '{16'd3, 16'd5, 16'd3, 4'h0, 16'd8}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic p);
    presenceIn = p;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    finishRun();
  end

  initial begin
    int prevCode;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 guard at reset", int'(guardOut), 0);
    chk("R9 steer at reset", int'(steerOut), 0);
    chk("R9 code at reset", int'(codeOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    prevCode = 0;

    for (int v = 0; v < NVEC; v++) begin
      int aEff, sEff, rEff, hi, total;
      int gRise, gFall, sRise, sFall;
      bit accept;
      acqCycles    = VECS[v].acq;
      settleCycles = VECS[v].settle;
      relCycles    = VECS[v].rel;
      codeIn       = VECS[v].code;
      aEff = (VECS[v].acq == 0) ? 1 : int'(VECS[v].acq);
      sEff = (VECS[v].settle == 0) ? 1 : int'(VECS[v].settle);
      rEff = (VECS[v].rel == 0) ? 1 : int'(VECS[v].rel);
      hi   = int'(VECS[v].hiLen);
      accept = (hi >= aEff);
      total = hi + rEff + 4;
      gRise = 0; gFall = 0; sRise = 0; sFall = 0;
      for (int c = 1; c <= total; c++) begin
        step(c <= hi);
        if (guardOut && gRise == 0) gRise = c;
        if (!guardOut && gRise != 0 && gFall == 0) gFall = c;
        if (steerOut && sRise == 0) sRise = c;
        if (!steerOut && sRise != 0 && sFall == 0) sFall = c;
      end
      if (accept) begin
        chk("R1 guard rise cycle", gRise, aEff);
        chk("R3 guard fall cycle", gFall, hi + 1);
        chk("R4 steer rise cycle", sRise, aEff + sEff);
        chk("R6 steer fall cycle", sFall, hi + rEff);
        chk("R9 code kept after release", int'(codeOut), int'(VECS[v].code));
        prevCode = int'(VECS[v].code);
      end else begin
        chk("R7 short burst guard", gRise, 0);
        chk("R7 short burst steer", sRise, 0);
        chk("R7 short burst latch", int'(codeOut), prevCode);
      end
      step(1'b0);
    end

    // R6 dropout shorter than release, code change while held (R2)
    acqCycles = 16'd3; settleCycles = 16'd2; relCycles = 16'd5;
    codeIn = 4'h9;
    for (int c = 0; c < 6; c++) step(1'b1);
    chk("R4 steer high before dropout", int'(steerOut), 1);
    codeIn = 4'h2;
    for (int c = 0; c < 4; c++) step(1'b0);
    chk("R6 steer survives short dropout", int'(steerOut), 1);
    for (int c = 0; c < 2; c++) step(1'b1);
    chk("R6 steer after tone returns", int'(steerOut), 1);
    chk("R3 guard stays low after dropout", int'(guardOut), 0);
    chk("R2 latch ignores code change", int'(codeOut), 9);
    for (int c = 0; c < 4; c++) step(1'b0);
    chk("R6 steer before release limit", int'(steerOut), 1);
    step(1'b0);
    chk("R6 steer at release limit", int'(steerOut), 0);
    step(1'b0);

    // R8 acquisition restart on a gap
    acqCycles = 16'd4; settleCycles = 16'd1; relCycles = 16'd1;
    codeIn = 4'h6;
    for (int c = 0; c < 3; c++) step(1'b1);
    step(1'b0);
    for (int c = 0; c < 3; c++) step(1'b1);
    chk("R8 split runs not registered", int'(guardOut), 0);
    step(1'b0);
    chk("R8 latch unchanged after split runs", int'(codeOut), 9);
    step(1'b0);
    for (int c = 0; c < 3; c++) step(1'b1);
    chk("R8 third sample not enough", int'(guardOut), 0);
    step(1'b1);
    chk("R1 fourth sample registers", int'(guardOut), 1);
    chk("R2 new code latched", int'(codeOut), 6);

    // R5 output enable gating
    outEnable = 1'b0;
    #1;
    chk("R5 bus off code", int'(codeOut), 0);
    chk("R5 bus off drive", int'(busDrive), 0);
    outEnable = 1'b1;
    #1;
    chk("R5 bus on code", int'(codeOut), 6);
    chk("R5 bus on drive", int'(busDrive), 1);
    @(negedge clk);
    for (int c = 0; c < 4; c++) step(1'b0);

    finishRun();
  end

endmodule